// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the host-facing side of a real-time clock. A host sees two byte addresses. A write to the even address selects one byte of a 128-byte register space. An access to the odd address then reads or writes the selected byte. Most bytes are plain storage: the time fields, the alarm fields and general-purpose bytes. Four control bytes follow their own rules: a mode register with a read-only busy bit, an enable register with a hold bit, a flag register that is cleared by reading it, and a fixed status byte.

The time-keeping and rate logic sit next to this block. They send three strobes. `upd_start` opens an update. `upd_done` ends it and carries the fresh seconds, minutes and hours values, already in register format. `per_tick` marks a periodic event. From these strobes the block refreshes the time bytes and compares the alarm bytes. It sets the event flags for the sources that are enabled and drives a level interrupt that stays high until software reads the flag register.

Top module: `rtc_regport`

## Requirements
- R1: After reset, mode register A (index 10) reads 0x26, enable register B (index 11) reads 0x02, flag register C (index 12) reads 0x00, status D (index 13) reads 0x80, the selected index is 0 and `irq` is low.
- R2: A write to the even address (`acc_addr`=0) stores `wdata[6:0]` as the index. A read of the even address returns 0xFF.
- R3: Odd-address reads and writes to indices 0–9 and 14–127 access plain byte storage. Reads return the value last written to that index.
- R4: Bit 7 of register A (busy) cannot be written. A write to A stores only bits 6:0. `upd_start` sets bit 7 when B bit 7 is clear, and `upd_done` clears it.
- R5: A write to B with bit 7 (hold) set stores the value with bit 4 (update-event enable) forced to 0, and it clears A bit 7.
- R6: Writes to indices 12 and 13 change nothing.
- R7: `per_tick` with B bit 6 set sets C bits 6 and 7. `upd_done` with B bit 4 set sets C bits 4 and 7. An alarm match sets C bits 5 and 7. `irq` follows C bit 7 one cycle after the strobe.
- R8: An alarm match needs B bit 5 set and an `upd_done` where each alarm byte (index 1 for seconds, 3 for minutes, 5 for hours) either equals the incoming value or has bits 7:6 both set.
- R9: On `upd_done` with B bit 7 clear, indices 0, 2 and 4 take `tm_sec`, `tm_min` and `tm_hour`. While B bit 7 is set they keep their values. A host write to the same index in the same cycle takes priority.
- R10: A read of C returns its current value, and C is 0x00 from the next cycle with `irq` low. A flag set by a strobe in the same cycle as the read is kept.
- R11: `sys_clr` clears B bits 6, 5 and 3 and all of C, and it drops `irq`. It takes priority over strobes and writes in the same cycle.
- R12: `ctl_a` and `ctl_b` always show the current contents of registers A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational for the current address and index |
| upd_start | input | 1 | Update begins |
| upd_done | input | 1 | Update ends, time values valid |
| per_tick | input | 1 | Periodic event |
| sys_clr | input | 1 | Synchronous system clear of enables and flags |
| tm_sec | input | 8 | Refreshed seconds value |
| tm_min | input | 8 | Refreshed minutes value |
| tm_hour | input | 8 | Refreshed hours value |
| irq | output | 1 | Level interrupt |
| ctl_a | output | 8 | Register A contents |
| ctl_b | output | 8 | Register B contents |

## Verification
The hardest situations to reach are the ones where two events land in the same cycle. One is a flag-register read in the same cycle as a periodic or update strobe, which must keep the new flag. Another is an `upd_done` carrying a time value during the cycle that writes that same time byte, or while hold is set. The directed sequence sets these up by issuing the strobe in the same step as the host access. A long random phase then narrows the index to the control range and the time values to a few alarm-matching choices, so that these collisions occur many times over. A behavioural reference model is compared on every cycle.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int BYTE_W = 8;

  // register indices the decode depends on
  localparam int IX_SEC  = 0;
  localparam int IX_ASEC = 1;
  localparam int IX_MIN  = 2;
  localparam int IX_AMIN = 3;
  localparam int IX_HR   = 4;
  localparam int IX_AHR  = 5;
  localparam int IX_CTLA = 10;
  localparam int IX_CTLB = 11;
  localparam int IX_FLAG = 12;
  localparam int IX_FIXD = 13;

  // mode register A
  localparam int A_BUSY = 7;
  // enable register B
  localparam int B_HOLD = 7;
  localparam int B_PEN  = 6;
  localparam int B_AEN  = 5;
  localparam int B_UEN  = 4;
  localparam int B_SQW  = 3;
  // flag register C
  localparam int F_ANY = 7;
  localparam int F_PER = 6;
  localparam int F_ALM = 5;
  localparam int F_UPD = 4;

  localparam logic [BYTE_W-1:0] A_INIT  = 8'h26;
  localparam logic [BYTE_W-1:0] B_INIT  = 8'h02;
  localparam logic [BYTE_W-1:0] D_FIXED = 8'h80;
  localparam logic [BYTE_W-1:0] B_CLR_MASK = 8'h68;

  localparam int ALM_FIELDS = 3;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_regport_pkg::*;
#(
  parameter int N = ALM_FIELDS
) (
  input  logic [N-1:0][BYTE_W-1:0] alm_i,
  input  logic [N-1:0][BYTE_W-1:0] cur_i,
  output logic                     hit_o
);
  logic [N-1:0] fld_ok;

  for (genvar i = 0; i < N; i++) begin : g_fld
    // a field matches on equality or when both top bits are set
    assign fld_ok[i] = (alm_i[i][BYTE_W-1 -: 2] == 2'b11) || (alm_i[i] == cur_i[i]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_regport_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  rf_en,
  input  logic [BYTE_W-1:0]     rf_sec,
  input  logic [BYTE_W-1:0]     rf_min,
  input  logic [BYTE_W-1:0]     rf_hr,
  input  logic [IW-1:0]         rd_idx,
  output logic [BYTE_W-1:0]     rd_data,
  output logic [ALM_FIELDS-1:0][BYTE_W-1:0] alm_o
);
  logic [DEPTH-1:0][BYTE_W-1:0] ent_w;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam bit RF_HIT = (g == IX_SEC) || (g == IX_MIN) || (g == IX_HR);
    logic [BYTE_W-1:0] rf_val;
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] nxt;
    logic              hit_wr;
    logic              ld;

    if (g == IX_SEC) begin : g_rs
      assign rf_val = rf_sec;
    end else if (g == IX_MIN) begin : g_rm
      assign rf_val = rf_min;
    end else if (g == IX_HR) begin : g_rh
      assign rf_val = rf_hr;
    end else begin : g_rn
      assign rf_val = '0;
    end

    assign hit_wr = wr_en && (wr_idx == IW'(g));

    always_comb begin
      nxt = q;
      ld  = 1'b0;
      if (RF_HIT && rf_en) begin
        nxt = rf_val;
        ld  = 1'b1;
      end
      // host write wins over a refresh in the same cycle
      if (hit_wr) begin
        nxt = wr_data;
        ld  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld) begin
        q <= nxt;
      end
    end

    assign ent_w[g] = q;
  end

  assign rd_data  = ent_w[rd_idx];
  assign alm_o[0] = ent_w[IX_ASEC];
  assign alm_o[1] = ent_w[IX_AMIN];
  assign alm_o[2] = ent_w[IX_AHR];
endmodule

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              upd_start,
  input  logic              upd_done,
  input  logic              sys_clr,
  output logic [BYTE_W-1:0] a_q,
  output logic [BYTE_W-1:0] b_q
);
  logic [BYTE_W-1:0] a_nxt;
  logic [BYTE_W-1:0] b_nxt;
  logic              a_ld;
  logic              b_ld;

  always_comb begin
    a_nxt = a_q;
    if (wr_a) begin
      a_nxt[A_BUSY-1:0] = wdata[A_BUSY-1:0];
    end
    if (upd_start && !b_q[B_HOLD]) a_nxt[A_BUSY] = 1'b1;
    if (upd_done)                  a_nxt[A_BUSY] = 1'b0;
    if (wr_b && wdata[B_HOLD])     a_nxt[A_BUSY] = 1'b0;

    b_nxt = b_q;
    if (wr_b) begin
      b_nxt = wdata;
      if (wdata[B_HOLD]) b_nxt[B_UEN] = 1'b0;
    end
    if (sys_clr) b_nxt = b_nxt & ~B_CLR_MASK;
  end

  assign a_ld = wr_a | wr_b | upd_start | upd_done;
  assign b_ld = wr_b | sys_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_INIT;
    end else if (a_ld) begin
      a_q <= a_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= B_INIT;
    end else if (b_ld) begin
      b_q <= b_nxt;
    end
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_per,
  input  logic              en_upd,
  input  logic              en_alm,
  input  logic              per_tick,
  input  logic              upd_done,
  input  logic              alarm_hit,
  input  logic              rd_clr,
  input  logic              sys_clr,
  output logic [BYTE_W-1:0] c_q,
  output logic              irq_o
);
  logic [BYTE_W-1:0] set_v;
  logic [BYTE_W-1:0] c_nxt;
  logic              c_ld;

  always_comb begin
    set_v        = '0;
    set_v[F_PER] = per_tick && en_per;
    set_v[F_UPD] = upd_done && en_upd;
    set_v[F_ALM] = upd_done && en_alm && alarm_hit;
    set_v[F_ANY] = set_v[F_PER] | set_v[F_UPD] | set_v[F_ALM];

    // events in the read cycle survive the clear
    c_nxt = (rd_clr ? '0 : c_q) | set_v;
    if (sys_clr) c_nxt = '0;
  end

  assign c_ld = rd_clr | sys_clr | set_v[F_ANY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
    end else if (c_ld) begin
      c_q <= c_nxt;
    end
  end

  assign irq_o = c_q[F_ANY];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              upd_start,
  input  logic              upd_done,
  input  logic              per_tick,
  input  logic              sys_clr,
  input  logic [BYTE_W-1:0] tm_sec,
  input  logic [BYTE_W-1:0] tm_min,
  input  logic [BYTE_W-1:0] tm_hour,
  output logic              irq,
  output logic [BYTE_W-1:0] ctl_a,
  output logic [BYTE_W-1:0] ctl_b
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // index register
  logic [IW-1:0] idx_q;
  logic          idx_ld;

  assign idx_ld = acc_en && acc_wr && !acc_addr;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idx_q <= '0;
    end else if (idx_ld) begin
      idx_q <= wdata[IW-1:0];
    end
  end

  // decode
  logic data_wr;
  logic data_rd;
  logic sel_a;
  logic sel_b;
  logic sel_c;
  logic sel_d;
  logic store_wr;
  logic rd_clr;

  assign data_wr  = acc_en && acc_wr && acc_addr;
  assign data_rd  = acc_en && !acc_wr && acc_addr;
  assign sel_a    = (idx_q == IW'(IX_CTLA));
  assign sel_b    = (idx_q == IW'(IX_CTLB));
  assign sel_c    = (idx_q == IW'(IX_FLAG));
  assign sel_d    = (idx_q == IW'(IX_FIXD));
  assign store_wr = data_wr && !(sel_a || sel_b || sel_c || sel_d);
  assign rd_clr   = data_rd && sel_c;

  logic [BYTE_W-1:0] a_q;
  logic [BYTE_W-1:0] b_q;
  logic [BYTE_W-1:0] c_q;
  logic [BYTE_W-1:0] st_rd;
  logic [ALM_FIELDS-1:0][BYTE_W-1:0] alm_w;
  logic [ALM_FIELDS-1:0][BYTE_W-1:0] cur_w;
  logic              alarm_hit;

  assign cur_w[0] = tm_sec;
  assign cur_w[1] = tm_min;
  assign cur_w[2] = tm_hour;

  rtc_byte_store #(.DEPTH(DEPTH), .IW(IW)) store_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (store_wr),
    .wr_idx  (idx_q),
    .wr_data (wdata),
    .rf_en   (upd_done && !b_q[B_HOLD]),
    .rf_sec  (tm_sec),
    .rf_min  (tm_min),
    .rf_hr   (tm_hour),
    .rd_idx  (idx_q),
    .rd_data (st_rd),
    .alm_o   (alm_w)
  );

  rtc_ctl_regs ctl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_a      (data_wr && sel_a),
    .wr_b      (data_wr && sel_b),
    .wdata     (wdata),
    .upd_start (upd_start),
    .upd_done  (upd_done),
    .sys_clr   (sys_clr),
    .a_q       (a_q),
    .b_q       (b_q)
  );

  rtc_alarm_cmp #(.N(ALM_FIELDS)) alm_i (
    .alm_i (alm_w),
    .cur_i (cur_w),
    .hit_o (alarm_hit)
  );

  rtc_flag_reg flag_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_per    (b_q[B_PEN]),
    .en_upd    (b_q[B_UEN]),
    .en_alm    (b_q[B_AEN]),
    .per_tick  (per_tick),
    .upd_done  (upd_done),
    .alarm_hit (alarm_hit),
    .rd_clr    (rd_clr),
    .sys_clr   (sys_clr),
    .c_q       (c_q),
    .irq_o     (irq)
  );

  // read mux
  always_comb begin
    if (!acc_addr)  rdata = 8'hFF;
    else if (sel_a) rdata = a_q;
    else if (sel_b) rdata = b_q;
    else if (sel_c) rdata = c_q;
    else if (sel_d) rdata = D_FIXED;
    else            rdata = st_rd;
  end

  assign ctl_a = a_q;
  assign ctl_b = b_q;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_wr,
  input logic          acc_addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          upd_start,
  input logic          upd_done,
  input logic          per_tick,
  input logic          sys_clr,
  input logic          irq,
  input logic [7:0]    ctl_a,
  input logic [7:0]    ctl_b,
  input logic [IW-1:0] idx_q,
  input logic [7:0]    c_q
);
  // R2
  even_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !acc_addr) |-> (rdata == 8'hFF));

  // R10
  flag_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr && idx_q == IW'(12) && !per_tick && !upd_done)
    |=> (c_q == 8'h00 && !irq));

  // R6
  flag_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr && idx_q == IW'(12) && !per_tick && !upd_done && !sys_clr)
    |=> $stable(c_q));

  // R4
  busy_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr && idx_q == IW'(10) && !upd_start && !upd_done)
    |=> $stable(ctl_a[7]));

  // R5
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr && idx_q == IW'(11) && wdata[7])
    |=> (!ctl_b[4] && !ctl_a[7]));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(per_tick || upd_done));

  // R11
  sys_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr |=> (!irq && (ctl_b & 8'h68) == 8'h00));
endmodule

bind rtc_regport rtc_regport_chk #(.IW(IW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .upd_start (upd_start),
  .upd_done  (upd_done),
  .per_tick  (per_tick),
  .sys_clr   (sys_clr),
  .irq       (irq),
  .ctl_a     (ctl_a),
  .ctl_b     (ctl_b),
  .idx_q     (idx_q),
  .c_q       (c_q)
);

// File: tb/rtc_regport_tb.sv
`timescale 1ns/1ps
module rtc_regport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_wr = 1'b0, acc_addr = 1'b0;
  logic [7:0] wdata = '0;
  logic       upd_start = 1'b0, upd_done = 1'b0, per_tick = 1'b0, sys_clr = 1'b0;
  logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
  logic [7:0] rdata, ctl_a, ctl_b;
  logic       irq;

  always #2 clk = ~clk;

  rtc_regport dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .wdata(wdata), .rdata(rdata), .upd_start(upd_start), .upd_done(upd_done),
    .per_tick(per_tick), .sys_clr(sys_clr), .tm_sec(tm_sec), .tm_min(tm_min),
    .tm_hour(tm_hour), .irq(irq), .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_mem [128];
  logic [7:0] m_a, m_b, m_c;
  int         m_idx;

  function automatic bit alm_ok(logic [7:0] al, logic [7:0] cur);
    return (al[7:6] == 2'b11) || (al == cur);
  endfunction

  task automatic step(input bit en, input bit wr, input bit ad, input logic [7:0] wd,
                      input bit us, input bit ud, input bit pt, input bit sc,
                      input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                      input string tag);
    logic [7:0] exp_rd, na, nb, nc;
    bit dwr, ah;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_addr = ad; wdata = wd;
    upd_start = us; upd_done = ud; per_tick = pt; sys_clr = sc;
    tm_sec = s; tm_min = m; tm_hour = h;
    #1;
    if (!ad)             exp_rd = 8'hFF;
    else if (m_idx == 10) exp_rd = m_a;
    else if (m_idx == 11) exp_rd = m_b;
    else if (m_idx == 12) exp_rd = m_c;
    else if (m_idx == 13) exp_rd = 8'h80;
    else                  exp_rd = m_mem[m_idx];
    n_run++;
    if (rdata !== exp_rd || irq !== m_c[7] || ctl_a !== m_a || ctl_b !== m_b) begin
      n_fail++;
      $display("FAIL %s: rdata=%02h exp %02h irq=%0b exp %0b ctl_a=%02h exp %02h ctl_b=%02h exp %02h",
               tag, rdata, exp_rd, irq, m_c[7], ctl_a, m_a, ctl_b, m_b);
    end
    @(posedge clk);
    // model update from pre-edge state
    dwr = en && wr && ad;
    ah  = ud && m_b[5] && alm_ok(m_mem[1], s) && alm_ok(m_mem[3], m) && alm_ok(m_mem[5], h);
    nc = (en && !wr && ad && m_idx == 12) ? 8'h00 : m_c;
    if (pt && m_b[6]) nc |= 8'hC0;
    if (ud && m_b[4]) nc |= 8'h90;
    if (ah)           nc |= 8'hA0;
    if (sc)           nc = 8'h00;
    na = m_a;
    if (dwr && m_idx == 10) na = (wd & 8'h7F) | (m_a & 8'h80);
    if (us && !m_b[7]) na |= 8'h80;
    if (ud) na &= 8'h7F;
    if (dwr && m_idx == 11 && wd[7]) na &= 8'h7F;
    nb = m_b;
    if (dwr && m_idx == 11) nb = wd[7] ? (wd & 8'hEF) : wd;
    if (sc) nb &= 8'h97;
    if (ud && !m_b[7]) begin
      m_mem[0] = s; m_mem[2] = m; m_mem[4] = h;
    end
    if (dwr && !(m_idx >= 10 && m_idx <= 13)) m_mem[m_idx] = wd;
    if (en && wr && !ad) m_idx = int'(wd & 8'h7F);
    m_a = na; m_b = nb; m_c = nc;
  endtask

  task automatic set_idx(input int i, input string tag);
    step(1, 1, 0, 8'(i), 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_d(input logic [7:0] v, input string tag);
    step(1, 1, 1, v, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_d(input string tag);
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_a = 8'h26; m_b = 8'h02; m_c = 8'h00; m_idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd_d("R1 index0");
    set_idx(10, "R1"); rd_d("R1 regA");
    set_idx(11, "R1"); rd_d("R1 regB");
    set_idx(12, "R1"); rd_d("R1 regC");
    set_idx(13, "R1"); rd_d("R1 regD");

    // R2 index masking and even read
    set_idx(8'h8A, "R2 masked index");
    rd_d("R2 masked index reads A");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 even read");

    // R3 plain storage
    set_idx(8'h40, "R3"); wr_d(8'h5A, "R3"); rd_d("R3 general byte");
    set_idx(8'h7F, "R3"); wr_d(8'hA5, "R3"); rd_d("R3 top byte");
    set_idx(7, "R3"); wr_d(8'h31, "R3"); rd_d("R3 day byte");

    // R4 busy bit read-only
    set_idx(10, "R4"); wr_d(8'hFF, "R4"); rd_d("R4 write keeps busy");
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R4 upd_start");
    rd_d("R4 busy set");
    wr_d(8'h26, "R4"); rd_d("R4 write keeps busy set");
    step(0, 0, 1, 0, 0, 1, 0, 0, 8'h11, 8'h22, 8'h03, "R4 upd_done");
    rd_d("R4 busy clear");

    // R5 hold write
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R5 busy set");
    set_idx(11, "R5"); wr_d(8'hF2, "R5 hold write"); rd_d("R5 uen forced low");
    set_idx(10, "R5"); rd_d("R5 busy cleared");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R5 start ignored in hold");
    rd_d("R5 busy stays clear");

    // R9 refresh suppressed in hold, then active
    set_idx(0, "R9");
    step(1, 0, 1, 0, 0, 1, 0, 0, 8'h59, 8'h58, 8'h23, "R9 no refresh in hold");
    rd_d("R9 sec kept");
    set_idx(11, "R9"); wr_d(8'h02, "R9 leave hold");
    set_idx(2, "R9");
    step(1, 0, 1, 0, 0, 1, 0, 0, 8'h07, 8'h08, 8'h09, "R9 refresh");
    rd_d("R9 min refreshed");
    step(1, 1, 1, 8'h44, 0, 1, 0, 0, 8'h01, 8'h02, 8'h03, "R9 host write wins");
    rd_d("R9 host value kept");

    // R6 C and D ignore writes
    set_idx(12, "R6"); wr_d(8'hFF, "R6"); rd_d("R6 C unchanged");
    set_idx(13, "R6"); wr_d(8'h00, "R6"); rd_d("R6 D unchanged");

    // R7 periodic flag, R10 read clear
    set_idx(11, "R7"); wr_d(8'h42, "R7 pen");
    step(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R7 per_tick");
    idle("R7 irq high");
    set_idx(12, "R10");
    rd_d("R10 read C");
    rd_d("R10 C cleared");
    step(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R10 set again");
    step(1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R10 read with strobe");
    rd_d("R10 flag kept");
    rd_d("R10 cleared");

    // R7 update flag
    set_idx(11, "R7"); wr_d(8'h12, "R7 uen");
    step(0, 0, 1, 0, 0, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R7 upd flag");
    set_idx(12, "R7"); rd_d("R7 C update flag");

    // R8 alarm
    set_idx(1, "R8"); wr_d(8'h30, "R8");
    set_idx(3, "R8"); wr_d(8'hC0, "R8");
    set_idx(5, "R8"); wr_d(8'h12, "R8");
    set_idx(11, "R8"); wr_d(8'h22, "R8 aen");
    step(0, 0, 1, 0, 0, 1, 0, 0, 8'h31, 8'h45, 8'h12, "R8 mismatch");
    idle("R8 no irq");
    step(0, 0, 1, 0, 0, 1, 0, 0, 8'h30, 8'h45, 8'h12, "R8 match wildcard min");
    set_idx(12, "R8"); rd_d("R8 alarm flag");
    set_idx(11, "R8"); wr_d(8'h02, "R8 aen off");
    step(0, 0, 1, 0, 0, 1, 0, 0, 8'h30, 8'h45, 8'h12, "R8 disabled");
    set_idx(12, "R8"); rd_d("R8 no flag");

    // R11 system clear
    set_idx(11, "R11"); wr_d(8'h7A, "R11");
    step(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, "R11 flag");
    step(0, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R11 clear beats strobe");
    rd_d("R11 B masked");
    set_idx(12, "R11"); rd_d("R11 C zero");

    // R12 random mix, compared every cycle
    for (int k = 0; k < 3000; k++) begin
      bit en, wr, ad, us, ud, pt, sc;
      logic [7:0] wd;
      en = ($urandom_range(0, 2) != 0);
      wr = $urandom_range(0, 1);
      ad = ($urandom_range(0, 3) != 0);
      if (en && wr && !ad)
        wd = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
      else
        wd = ($urandom_range(0, 1) != 0) ? 8'($urandom) : 8'($urandom_range(0, 1) ? 8'h30 : 8'hC0);
      us = ($urandom_range(0, 7) == 0);
      ud = ($urandom_range(0, 7) == 0);
      pt = ($urandom_range(0, 5) == 0);
      sc = ($urandom_range(0, 63) == 0);
      step(en, wr, ad, wd, us, ud, pt, sc,
           $urandom_range(0, 1) ? 8'h30 : 8'h31,
           $urandom_range(0, 1) ? 8'hC0 : 8'h45,
           $urandom_range(0, 1) ? 8'h12 : 8'h30, "R12 random mix");
    end

    idle("R12 final");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule